// File: doc/BRIEF.md
# Bus Multiplexer Power-Up Lockout and Channel Connect Sequencer

This block decides when the shared input side of a one-to-two bidirectional bus multiplexer may be joined to each of its two output channels. It watches two supply comparator flags: one says the primary supply is good, the other says the secondary supply is above its threshold. It also takes two channel enable requests and a disconnect request from a stuck-bus recovery controller. From these it drives the connection gate enables, the input-side and per-channel output-side edge accelerator enables, the buffer enable, and a select that picks the supply for the gate drive.

A blanking window of `BLANK_US` microsecond ticks follows each power event. A tick comes from an external prescaler. The window starts when the primary flag rises, and again when the secondary flag changes in either direction. During the window everything is disabled and the enable requests are ignored. Once the recovery controller has asked for a disconnect, the channels stay disconnected until both enable requests have been low together. The desired channels are then requested again.

The asynchronous flags and enable requests pass through two-flop synchronizers. All state uses a synchronous active-low reset. Outputs are registered.

Top module: `mux_connect_seq`

## Requirements
- R1: After reset, all gate, accelerator and buffer enables are 0 and the block is in lockout.
- R2: While `pri_ok` is low, the block stays in lockout. After `pri_ok` rises, all gates stay off for `BLANK_US` ticks of `us_tick`, even if enables are requested. They then follow the requests.
- R3: Any transition of `sec_ok`, rising or falling, forces all enables off and restarts the `BLANK_US`-tick blanking window.
- R4: Outside lockout and fault blocking, `conn_en[i]` follows `chan_req[i]` for channel i (bit 0 is channel 0). Both channels may be connected at once.
- R5: `acc_in_en` is high exactly when at least one channel is connected. `acc_out_en[i]` is high only when channel i is connected and `sec_ok` is high.
- R6: `buf_en` is high exactly when at least one channel is connected.
- R7: `gate_sup_sel` is 1 (secondary supply) when the synchronized `sec_ok` is high, and 0 (primary supply) otherwise.
- R8: While `flt_disc` is high, every `conn_en` bit is 0 whatever the requests are.
- R9: After a disconnect request ends, no channel reconnects until both `chan_req` bits have been sampled low in the same cycle outside lockout. Requests raised after that connect normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse each microsecond, from the prescaler |
| pri_ok | input | 1 | Primary supply good (asynchronous) |
| sec_ok | input | 1 | Secondary supply above threshold (asynchronous) |
| chan_req | input | NCH | Per-channel enable requests (asynchronous) |
| flt_disc | input | 1 | Disconnect request from the recovery controller (synchronous) |
| conn_en | output | NCH | Per-channel connection gate enables |
| acc_in_en | output | 1 | Input-side edge accelerator enable |
| acc_out_en | output | NCH | Per-channel output-side accelerator enables |
| buf_en | output | 1 | Buffer enable |
| gate_sup_sel | output | 1 | Gate supply select: 1 secondary, 0 primary |

## Verification
On every cycle, the assertions check the following:
- Lockout, a disconnect request and fault blocking each leave the gates off.
- Output accelerators stay off without the secondary supply.
- A secondary flag change always restarts lockout.
- Lockout ends only when the tick count reaches `BLANK_US`.
- The counter never exceeds that limit.

Only the bench scenarios can show the rest:
- The blanking window really lasts its full length after each kind of power event.
- Enable requests raised during that window take effect afterwards.
- Re-arming after a fault needs both requests low at the same time, not one after the other.

// File: rtl/mux_connect_seq_pkg.sv
package mux_connect_seq_pkg;

  // Next value of the blanking counter: saturate at the limit.
  function automatic int unsigned blank_next(input int unsigned cnt, input int unsigned limit);
    return (cnt >= limit) ? limit : cnt + 1;
  endfunction

  // True when the tick that arrives at this count closes the window.
  function automatic logic blank_last(input int unsigned cnt, input int unsigned limit);
    return (cnt + 1) >= limit;
  endfunction

  // Gate decision for one channel.
  function automatic logic gate_allow(input logic req, input logic lock, input logic blocked,
                                      input logic disc);
    return req & ~lock & ~blocked & ~disc;
  endfunction

endpackage

// File: rtl/mcs_sync2.sv
module mcs_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/mcs_lock_timer.sv
module mcs_lock_timer
  import mux_connect_seq_pkg::*;
#(
  parameter int BLANK_US = 110,
  localparam int CW = $clog2(BLANK_US + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic us_tick,
  input  logic pri_s,
  input  logic sec_s,
  output logic lock_o,
  output logic restart_o
);
  logic          pri_prev_q;
  logic          sec_prev_q;
  logic [CW-1:0] cnt_q;
  logic          lock_q;
  logic          pri_rise;
  logic          sec_edge;

  assign pri_rise  = pri_s & ~pri_prev_q;
  assign sec_edge  = sec_s ^ sec_prev_q;
  assign restart_o = pri_rise | sec_edge;
  assign lock_o    = lock_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pri_prev_q <= 1'b0;
      sec_prev_q <= 1'b0;
      cnt_q      <= '0;
      lock_q     <= 1'b1;
    end else begin
      pri_prev_q <= pri_s;
      sec_prev_q <= sec_s;
      if (!pri_s || restart_o) begin
        cnt_q  <= '0;
        lock_q <= 1'b1;
      end else if (lock_q && us_tick) begin
        cnt_q <= CW'(blank_next(int'(cnt_q), BLANK_US));
        if (blank_last(int'(cnt_q), BLANK_US)) lock_q <= 1'b0;
      end
    end
  end

  // R3: a secondary flag edge always puts the block back in lockout
  assert_sec_edge_relock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sec_edge |=> lock_q);

  // R2: lockout ends only on the tick that completes the window
  assert_lock_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_q) |-> ($past(cnt_q) == CW'(BLANK_US - 1)) && $past(us_tick));

  // R2: the counter never runs past the window
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(BLANK_US));

  // R2: the primary flag low keeps lockout
  assert_pri_low_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pri_s |=> lock_q);
endmodule

// File: rtl/mcs_rearm.sv
module mcs_rearm #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           lock_i,
  input  logic           disc_i,
  input  logic [NCH-1:0] req_s,
  output logic           blocked_o
);
  logic blocked_q;
  logic all_low;

  assign all_low   = (req_s == '0);
  assign blocked_o = blocked_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blocked_q <= 1'b0;
    end else if (disc_i) begin
      blocked_q <= 1'b1;
    end else if (blocked_q && all_low && !lock_i) begin
      blocked_q <= 1'b0;
    end
  end

  // R9: blocking ends only after both requests were seen low outside lockout
  assert_rearm_cond_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(blocked_q) |-> $past(all_low) && !$past(lock_i) && !$past(disc_i));

  // R8: a disconnect request always leaves the block blocked
  assert_disc_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    disc_i |=> blocked_q);
endmodule

// File: rtl/mcs_chan_out.sv
module mcs_chan_out
  import mux_connect_seq_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req_s,
  input  logic           sec_s,
  input  logic           lock_i,
  input  logic           blocked_i,
  input  logic           disc_i,
  output logic [NCH-1:0] conn_o,
  output logic [NCH-1:0] acc_out_o,
  output logic           acc_in_o,
  output logic           buf_o,
  output logic           sel_o
);
  logic [NCH-1:0] conn_d;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign conn_d[i] = gate_allow(req_s[i], lock_i, blocked_i, disc_i);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        conn_o[i]    <= 1'b0;
        acc_out_o[i] <= 1'b0;
      end else begin
        conn_o[i]    <= conn_d[i];
        acc_out_o[i] <= conn_d[i] & sec_s;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_in_o <= 1'b0;
      buf_o    <= 1'b0;
      sel_o    <= 1'b0;
    end else begin
      acc_in_o <= |conn_d;
      buf_o    <= |conn_d;
      sel_o    <= sec_s;
    end
  end

  // R2: lockout leaves every gate off
  assert_lock_gates_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lock_i |=> conn_o == '0);

  // R8: a disconnect request leaves every gate off
  assert_disc_gates_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    disc_i |=> conn_o == '0);

  // R9: while blocked, no channel connects
  assert_blocked_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    blocked_i |=> conn_o == '0);

  // R5: no output accelerator without the secondary supply
  assert_no_out_acc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_s |=> acc_out_o == '0);

  // R5: an output accelerator implies its gate
  assert_out_acc_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_out_o & ~conn_o) == '0);
endmodule

// File: rtl/mux_connect_seq.sv
module mux_connect_seq #(
  parameter int NCH      = 2,
  parameter int BLANK_US = 110
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           us_tick,
  input  logic           pri_ok,
  input  logic           sec_ok,
  input  logic [NCH-1:0] chan_req,
  input  logic           flt_disc,
  output logic [NCH-1:0] conn_en,
  output logic           acc_in_en,
  output logic [NCH-1:0] acc_out_en,
  output logic           buf_en,
  output logic           gate_sup_sel
);
  localparam int SW = NCH + 2;

  logic [SW-1:0]  raw_in;
  logic [SW-1:0]  sync_out;
  logic           pri_s;
  logic           sec_s;
  logic [NCH-1:0] req_s;
  logic           lock_w;
  logic           restart_w;
  logic           blocked_w;

  assign raw_in = {pri_ok, sec_ok, chan_req};
  assign pri_s  = sync_out[SW-1];
  assign sec_s  = sync_out[SW-2];
  assign req_s  = sync_out[NCH-1:0];

  mcs_sync2 #(.W(SW)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_out)
  );

  mcs_lock_timer #(.BLANK_US(BLANK_US)) u_timer (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .pri_s(pri_s), .sec_s(sec_s),
    .lock_o(lock_w), .restart_o(restart_w)
  );

  mcs_rearm #(.NCH(NCH)) u_rearm (
    .clk(clk), .rst_n(rst_n), .lock_i(lock_w), .disc_i(flt_disc), .req_s(req_s),
    .blocked_o(blocked_w)
  );

  mcs_chan_out #(.NCH(NCH)) u_out (
    .clk(clk), .rst_n(rst_n), .req_s(req_s), .sec_s(sec_s), .lock_i(lock_w),
    .blocked_i(blocked_w), .disc_i(flt_disc), .conn_o(conn_en), .acc_out_o(acc_out_en),
    .acc_in_o(acc_in_en), .buf_o(buf_en), .sel_o(gate_sup_sel)
  );

  // R3: a restart event is followed by a cycle with all gates off
  assert_restart_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    restart_w |=> ##1 conn_en == '0);

  // R6: buffer enable and input accelerator agree
  assert_buf_acc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    buf_en == acc_in_en);
endmodule

// File: tb/mux_connect_seq_bench.sv
module mux_connect_seq_bench;
  localparam int NCH = 2;
  localparam int BLANK_US = 110;
  localparam int TDIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic us_tick = 1'b0;
  logic pri_ok = 1'b0;
  logic sec_ok = 1'b0;
  logic [NCH-1:0] chan_req = '0;
  logic flt_disc = 1'b0;
  logic [NCH-1:0] conn_en;
  logic acc_in_en;
  logic [NCH-1:0] acc_out_en;
  logic buf_en;
  logic gate_sup_sel;

  int n_run = 0;
  int n_fail = 0;
  int tdiv_cnt = 0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (tdiv_cnt == TDIV - 1) begin
      tdiv_cnt <= 0;
      us_tick  <= 1'b1;
    end else begin
      tdiv_cnt <= tdiv_cnt + 1;
      us_tick  <= 1'b0;
    end
  end

  mux_connect_seq #(.NCH(NCH), .BLANK_US(BLANK_US)) u_mux_connect_seq (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .pri_ok(pri_ok), .sec_ok(sec_ok),
    .chan_req(chan_req), .flt_disc(flt_disc), .conn_en(conn_en), .acc_in_en(acc_in_en),
    .acc_out_en(acc_out_en), .buf_en(buf_en), .gate_sup_sel(gate_sup_sel)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    cyc(n * TDIV);
  endtask

  // outputs expected when a given channel mask is connected
  task automatic chk_conn(input string tag, input logic [NCH-1:0] m, input logic sec);
    chk({tag, " conn R4"}, int'(conn_en), int'(m));
    chk({tag, " acc_in R5"}, int'(acc_in_en), int'(|m));
    chk({tag, " acc_out R5"}, int'(acc_out_en), int'(sec ? m : '0));
    chk({tag, " buf R6"}, int'(buf_en), int'(|m));
    chk({tag, " sel R7"}, int'(gate_sup_sel), int'(sec));
  endtask

  task automatic t_reset;
    cyc(3);
    chk_conn("reset R1", '0, 1'b0);
    rst_n = 1'b1;
    chan_req = 2'b11;
    cyc(20);
    chk("no pri R2", int'(conn_en), 0);
  endtask

  task automatic t_powerup;
    sec_ok = 1'b1;
    pri_ok = 1'b1;
    ticks(BLANK_US - 10);
    chk("pwrup blank R2", int'(conn_en), 0);
    chk("pwrup buf off R2", int'(buf_en), 0);
    ticks(20);
    chk_conn("pwrup done R2", 2'b11, 1'b1);
  endtask

  task automatic t_channels;
    chan_req = 2'b01; cyc(6); chk_conn("ch0", 2'b01, 1'b1);
    chan_req = 2'b10; cyc(6); chk_conn("ch1", 2'b10, 1'b1);
    chan_req = 2'b00; cyc(6); chk_conn("none", 2'b00, 1'b1);
    chan_req = 2'b11; cyc(6); chk_conn("both", 2'b11, 1'b1);
  endtask

  task automatic t_sec_toggle;
    sec_ok = 1'b0;
    cyc(6);
    chk("sec fall off R3", int'(conn_en), 0);
    chk("sec fall sel R7", int'(gate_sup_sel), 0);
    ticks(BLANK_US - 10);
    chk("sec fall blank R3", int'(conn_en), 0);
    ticks(20);
    chk_conn("sec low R5", 2'b11, 1'b0);
    sec_ok = 1'b1;
    cyc(6);
    chk("sec rise off R3", int'(conn_en), 0);
    ticks(BLANK_US - 10);
    chk("sec rise blank R3", int'(conn_en), 0);
    ticks(20);
    chk_conn("sec high R5", 2'b11, 1'b1);
  endtask

  task automatic t_fault;
    @(negedge clk); flt_disc = 1'b1;
    cyc(2);
    chk("disc off R8", int'(conn_en), 0);
    cyc(10);
    chk("disc hold R8", int'(conn_en), 0);
    flt_disc = 1'b0;
    cyc(10);
    chk("post fault blocked R9", int'(conn_en), 0);
    chan_req = 2'b01; cyc(6);
    chan_req = 2'b10; cyc(6);
    chan_req = 2'b11; cyc(6);
    chk("staggered lows R9", int'(conn_en), 0);
    chan_req = 2'b00; cyc(6);
    chan_req = 2'b10; cyc(6);
    chk_conn("rearmed R9", 2'b10, 1'b1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_powerup();
        t_channels();
        t_sec_toggle();
        t_fault();
      end
      begin
        cyc(100000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog R1 actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule